// File: doc/BRIEF.md
# USB Upstream Line-State Event Monitor

This block samples the decoded state of the upstream USB pair (idle J, K, single-ended zero and the illegal SE1) once per cycle of a fixed 48 MHz clock. It turns runs of those states into five sticky event flags. The flags mark a valid end of packet, a 3 ms idle period (suspend is advised), a 5 ms idle period (remote wake-up is allowed), a bus reset (SE0 held for 2.5 µs) and resume signalling seen while the node is suspended. Firmware decides what to do with each event. The block itself never changes the node state.

The flags sit in an 8-bit event register, and a read of that register clears them. A read/write mask register uses the same bit layout. The OR of the flags that the mask enables drives one summary output, which feeds the main interrupt event register. All time thresholds are cycle counts set by parameters. An optional synchronizer depth can be placed in front of the line and suspend inputs.

Top module: `usb_linemon`

## Requirements
- R1: After reset the event register reads 0, the mask register reads 0 and `alt_o` is 0.
- R2: Line state encoding is 00 SE0, 01 J (idle), 10 K, 11 SE1. Event bit 1 (3 ms idle) sets on the edge that completes IDLE3_CYC consecutive J samples. Any non-J sample restarts the count. The bit sets only once per unbroken idle run.
- R3: Event bit 2 (5 ms idle) sets on the edge that completes IDLE5_CYC consecutive J samples, once per idle run.
- R4: Event bit 3 (bus reset) sets on the edge that completes SE0_RST_CYC consecutive SE0 samples, once per SE0 run.
- R5: Event bit 0 (end of packet) sets when a J sample directly follows an SE0 run whose length is at least EOP_MIN_CYC and below SE0_RST_CYC. A shorter or longer SE0 run, or an SE0 run that ends in K, does not set it.
- R6: Event bit 4 (resume) sets only while `susp_i` is 1, on the first non-J sample that follows a J sample. It sets once per non-idle run and never while `susp_i` is 0.
- R7: A read of address 0 returns the flags in bits 4..0 and clears them on that edge. A flag whose event occurs on the same edge as the read stays set.
- R8: Address 1 is the mask register. A write stores bits 4..0 and reads return them, with bits 7..5 of any read always 0. A write to address 0 has no effect.
- R9: `alt_o` is 1 exactly when some event flag is set whose mask bit is 1. A flag with its mask bit at 0 still sets and can be read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fixed-frequency sampling clock (48 MHz nominal) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_i | input | 2 | Decoded upstream line state: 00 SE0, 01 J, 10 K, 11 SE1 |
| susp_i | input | 1 | 1 while the node's functional state is suspended |
| rd_en_i | input | 1 | Register read strobe; a read of address 0 clears the flags |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | 0 selects the event register, 1 selects the mask register |
| wr_data_i | input | DW | Write data |
| rd_data_o | output | DW | Read data for the addressed register (combinational) |
| alt_o | output | 1 | Summary of the event flags the mask enables |

## Verification
A clear-on-read access and a new event can land on the same clock edge. If the clear wins, the event is lost. The bench issues a read of the event register in the very cycle in which an SE0 run reaches the bus-reset length. It expects the data returned by that read to show no reset flag, and it expects the next read to show the flag. A following read, with the line unchanged, must return zero, which shows that the flag is not raised a second time.

// File: rtl/usb_linemon_pkg.sv
package usb_linemon_pkg;

   typedef enum logic [1:0] {
      LS_SE0 = 2'b00,
      LS_J   = 2'b01,
      LS_K   = 2'b10,
      LS_SE1 = 2'b11
   } line_t;

   localparam int unsigned EV_EOP = 0;
   localparam int unsigned EV_SD3 = 1;
   localparam int unsigned EV_SD5 = 2;
   localparam int unsigned EV_RST = 3;
   localparam int unsigned EV_RES = 4;
   localparam int unsigned EV_NUM = 5;

   localparam logic ADR_EVT = 1'b0;
   localparam logic ADR_MSK = 1'b1;

endpackage

// File: rtl/usb_linemon_runcnt.sv
module usb_linemon_runcnt #(
   parameter int unsigned MAXV = 16,
   parameter int unsigned W    = $clog2(MAXV + 1)
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         hit_i,
   output logic [W-1:0] cnt_o
);

   localparam logic [W-1:0] CAP = W'(MAXV);

   if (MAXV < 2) begin : g_bad_max
      $error("usb_linemon_runcnt: MAXV must be at least 2");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_o <= '0;
      end else if (!hit_i) begin
         cnt_o <= '0;
      end else if (cnt_o != CAP) begin
         cnt_o <= cnt_o + 1'b1;
      end
   end

endmodule

// File: rtl/usb_linemon_detect.sv
module usb_linemon_detect
   import usb_linemon_pkg::*;
#(
   parameter int unsigned IDLE3_CYC   = 144000,
   parameter int unsigned IDLE5_CYC   = 240000,
   parameter int unsigned SE0_RST_CYC = 120,
   parameter int unsigned EOP_MIN_CYC = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  line_t             line_i,
   input  logic              susp_i,
   output logic [EV_NUM-1:0] set_o
);

   localparam int unsigned ICW = $clog2(IDLE5_CYC + 1);
   localparam int unsigned SCW = $clog2(SE0_RST_CYC + 1);
   localparam logic [ICW-1:0] IDLE3_LAST = ICW'(IDLE3_CYC - 1);
   localparam logic [ICW-1:0] IDLE5_LAST = ICW'(IDLE5_CYC - 1);
   localparam logic [SCW-1:0] RST_LAST   = SCW'(SE0_RST_CYC - 1);
   localparam logic [SCW-1:0] RST_LEN    = SCW'(SE0_RST_CYC);
   localparam logic [SCW-1:0] EOP_LEN    = SCW'(EOP_MIN_CYC);

   logic           idle_hit;
   logic           se0_hit;
   logic [ICW-1:0] idle_cnt;
   logic [SCW-1:0] se0_cnt;
   logic           prev_idle_q;

   assign idle_hit = (line_i == LS_J);
   assign se0_hit  = (line_i == LS_SE0);

   usb_linemon_runcnt #(
      .MAXV (IDLE5_CYC),
      .W    (ICW)
   ) u_idle_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .hit_i  (idle_hit),
      .cnt_o  (idle_cnt)
   );

   usb_linemon_runcnt #(
      .MAXV (SE0_RST_CYC),
      .W    (SCW)
   ) u_se0_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .hit_i  (se0_hit),
      .cnt_o  (se0_cnt)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_idle_q <= 1'b0;
      end else begin
         prev_idle_q <= idle_hit;
      end
   end

   always_comb begin
      set_o         = '0;
      set_o[EV_SD3] = idle_hit && (idle_cnt == IDLE3_LAST);
      set_o[EV_SD5] = idle_hit && (idle_cnt == IDLE5_LAST);
      set_o[EV_RST] = se0_hit && (se0_cnt == RST_LAST);
      set_o[EV_EOP] = idle_hit && (se0_cnt >= EOP_LEN) && (se0_cnt < RST_LEN);
      set_o[EV_RES] = susp_i && !idle_hit && prev_idle_q;
   end

endmodule

// File: rtl/usb_linemon_regs.sv
module usb_linemon_regs
   import usb_linemon_pkg::*;
#(
   parameter int unsigned DW = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [EV_NUM-1:0] set_i,
   input  logic              rd_en_i,
   input  logic              wr_en_i,
   input  logic              addr_i,
   input  logic [DW-1:0]     wr_data_i,
   output logic [DW-1:0]     rd_data_o,
   output logic [EV_NUM-1:0] evt_o,
   output logic [EV_NUM-1:0] msk_o,
   output logic              alt_o
);

   logic clr_rd;
   logic msk_we;
   logic unused_wr_hi;

   assign clr_rd       = rd_en_i && (addr_i == ADR_EVT);
   assign msk_we       = wr_en_i && (addr_i == ADR_MSK);
   assign unused_wr_hi = ^wr_data_i;

   for (genvar b = 0; b < EV_NUM; b++) begin : g_flag
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            evt_o[b] <= 1'b0;
         end else if (set_i[b]) begin
            evt_o[b] <= 1'b1;
         end else if (clr_rd) begin
            evt_o[b] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         msk_o <= '0;
      end else if (msk_we) begin
         msk_o <= wr_data_i[EV_NUM-1:0];
      end
   end

   always_comb begin
      rd_data_o             = '0;
      rd_data_o[EV_NUM-1:0] = (addr_i == ADR_MSK) ? msk_o : evt_o;
   end

   assign alt_o = |(evt_o & msk_o);

endmodule

// File: rtl/usb_linemon.sv
module usb_linemon
   import usb_linemon_pkg::*;
#(
   parameter int unsigned DW          = 8,
   parameter int unsigned IDLE3_CYC   = 144000,
   parameter int unsigned IDLE5_CYC   = 240000,
   parameter int unsigned SE0_RST_CYC = 120,
   parameter int unsigned EOP_MIN_CYC = 8,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic [1:0]    line_i,
   input  logic          susp_i,
   input  logic          rd_en_i,
   input  logic          wr_en_i,
   input  logic          addr_i,
   input  logic [DW-1:0] wr_data_i,
   output logic [DW-1:0] rd_data_o,
   output logic          alt_o
);

   if (DW <= EV_NUM) begin : g_bad_dw
      $error("usb_linemon: DW must exceed the event count");
   end
   if (IDLE3_CYC >= IDLE5_CYC) begin : g_bad_idle
      $error("usb_linemon: IDLE3_CYC must be below IDLE5_CYC");
   end
   if (EOP_MIN_CYC < 1 || EOP_MIN_CYC >= SE0_RST_CYC) begin : g_bad_eop
      $error("usb_linemon: EOP_MIN_CYC must lie in 1..SE0_RST_CYC-1");
   end
   if (SYNC_STAGES > 3) begin : g_bad_sync
      $error("usb_linemon: SYNC_STAGES limited to 3");
   end

   logic [2:0]        raw_in;
   logic [2:0]        syn_in;
   line_t             line_s;
   logic              susp_s;
   logic [EV_NUM-1:0] ev_set;
   logic [EV_NUM-1:0] evt_q;
   logic [EV_NUM-1:0] msk_q;

   assign raw_in = {susp_i, line_i};

   if (SYNC_STAGES == 0) begin : g_nosync
      assign syn_in = raw_in;
   end else begin : g_sync
      logic [2:0] pipe_q [SYNC_STAGES];
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            for (int i = 0; i < int'(SYNC_STAGES); i++) pipe_q[i] <= {1'b0, LS_K};
         end else begin
            pipe_q[0] <= raw_in;
            for (int i = 1; i < int'(SYNC_STAGES); i++) pipe_q[i] <= pipe_q[i-1];
         end
      end
      assign syn_in = pipe_q[SYNC_STAGES-1];
   end

   assign line_s = line_t'(syn_in[1:0]);
   assign susp_s = syn_in[2];

   usb_linemon_detect #(
      .IDLE3_CYC   (IDLE3_CYC),
      .IDLE5_CYC   (IDLE5_CYC),
      .SE0_RST_CYC (SE0_RST_CYC),
      .EOP_MIN_CYC (EOP_MIN_CYC)
   ) u_detect (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i (line_s),
      .susp_i (susp_s),
      .set_o  (ev_set)
   );

   usb_linemon_regs #(
      .DW (DW)
   ) u_regs (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .set_i     (ev_set),
      .rd_en_i   (rd_en_i),
      .wr_en_i   (wr_en_i),
      .addr_i    (addr_i),
      .wr_data_i (wr_data_i),
      .rd_data_o (rd_data_o),
      .evt_o     (evt_q),
      .msk_o     (msk_q),
      .alt_o     (alt_o)
   );

endmodule

// File: rtl/usb_linemon_chk.sv
module usb_linemon_chk
   import usb_linemon_pkg::*;
#(
   parameter int unsigned DW = 8
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic [1:0]        line_s,
   input logic              susp_s,
   input logic              rd_en_i,
   input logic              wr_en_i,
   input logic              addr_i,
   input logic [DW-1:0]     wr_data_i,
   input logic [DW-1:0]     rd_data_o,
   input logic              alt_o,
   input logic [EV_NUM-1:0] evt_q,
   input logic [EV_NUM-1:0] msk_q
);

   a_r2_sd3_after_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(evt_q[EV_SD3]) |-> $past(line_s) == LS_J);

   a_r3_sd5_after_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(evt_q[EV_SD5]) |-> $past(line_s) == LS_J);

   a_r4_reset_on_se0: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(evt_q[EV_RST]) |-> $past(line_s) == LS_SE0);

   a_r5_eop_on_j: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(evt_q[EV_EOP]) |-> $past(line_s) == LS_J);

   a_r6_resume_needs_susp: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(evt_q[EV_RES]) |-> ($past(susp_s) && $past(line_s) != LS_J));

   a_r7_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && addr_i == ADR_EVT && line_s == LS_K && !susp_s) |=> evt_q == '0);

   a_r7_flags_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(rd_en_i && addr_i == ADR_EVT) |=> (evt_q & $past(evt_q)) == $past(evt_q));

   a_r8_mask_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == ADR_MSK) |=> msk_q == $past(wr_data_i[EV_NUM-1:0]));

   a_r8_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_data_o >> EV_NUM) == '0);

   a_r9_alt_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
      alt_o |-> (evt_q & msk_q) != '0);

endmodule

bind usb_linemon usb_linemon_chk #(.DW(DW)) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .line_s    (line_s),
   .susp_s    (susp_s),
   .rd_en_i   (rd_en_i),
   .wr_en_i   (wr_en_i),
   .addr_i    (addr_i),
   .wr_data_i (wr_data_i),
   .rd_data_o (rd_data_o),
   .alt_o     (alt_o),
   .evt_q     (evt_q),
   .msk_q     (msk_q)
);

// File: tb/usb_linemon_tb.sv
module usb_linemon_tb;
   import usb_linemon_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 20000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] line = LS_K;
   logic       susp = 1'b0;
   logic       rd_en = 1'b0;
   logic       wr_en = 1'b0;
   logic       addr = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       alt;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   usb_linemon #(
      .DW          (8),
      .IDLE3_CYC   (30),
      .IDLE5_CYC   (50),
      .SE0_RST_CYC (20),
      .EOP_MIN_CYC (4),
      .SYNC_STAGES (0)
   ) u_dut (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .line_i    (line),
      .susp_i    (susp),
      .rd_en_i   (rd_en),
      .wr_en_i   (wr_en),
      .addr_i    (addr),
      .wr_data_i (wdata),
      .rd_data_o (rdata),
      .alt_o     (alt)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic hold(input logic [1:0] ls, input int n);
      line = ls;
      repeat (n) @(negedge clk);
   endtask

   task automatic reg_rd(input logic a, output logic [7:0] d);
      rd_en = 1'b1;
      addr  = a;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic reg_wr(input logic a, input logic [7:0] d);
      wr_en = 1'b1;
      addr  = a;
      wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      chk("R1 alt after reset", {7'd0, alt}, 8'h00);
      reg_rd(1'b0, d); chk("R1 event reg after reset", d, 8'h00);
      reg_rd(1'b1, d); chk("R1 mask reg after reset", d, 8'h00);
   endtask

   task automatic t_mask_rw();
      logic [7:0] d;
      reg_wr(1'b1, 8'hFF);
      reg_rd(1'b1, d); chk("R8 mask readback reserved zero", d, 8'h1F);
      reg_wr(1'b0, 8'hFF);
      reg_rd(1'b0, d); chk("R8 write to event addr ignored", d, 8'h00);
      chk("R8 alt after ignored write", {7'd0, alt}, 8'h00);
   endtask

   task automatic t_idle();
      logic [7:0] d;
      hold(LS_J, 29); chk("R2 no SD3 at 29 idle", {7'd0, alt}, 8'h00);
      hold(LS_J, 1);  chk("R2 SD3 at 30 idle", {7'd0, alt}, 8'h01);
      reg_rd(1'b0, d); chk("R2 SD3 bit", d, 8'h02);
      hold(LS_J, 18); chk("R3 no SD5 at 49 idle", {7'd0, alt}, 8'h00);
      hold(LS_J, 1);  chk("R3 SD5 at 50 idle", {7'd0, alt}, 8'h01);
      reg_rd(1'b0, d); chk("R3 SD5 bit", d, 8'h04);
      hold(LS_J, 100); chk("R2 R3 once per idle run", {7'd0, alt}, 8'h00);
      hold(LS_K, 1); hold(LS_J, 20); hold(LS_K, 1); hold(LS_J, 20);
      chk("R2 idle count restarts", {7'd0, alt}, 8'h00);
      hold(LS_J, 10); chk("R2 SD3 after restart", {7'd0, alt}, 8'h01);
      reg_rd(1'b0, d); chk("R2 SD3 bit after restart", d, 8'h02);
      hold(LS_K, 1);
   endtask

   task automatic t_busreset();
      logic [7:0] d;
      hold(LS_SE0, 19); chk("R4 no reset at 19", {7'd0, alt}, 8'h00);
      hold(LS_SE0, 1);  chk("R4 reset at 20", {7'd0, alt}, 8'h01);
      reg_rd(1'b0, d); chk("R4 reset bit", d, 8'h08);
      hold(LS_SE0, 40); chk("R4 once per SE0 run", {7'd0, alt}, 8'h00);
      hold(LS_J, 1);    chk("R5 no EOP after long SE0", {7'd0, alt}, 8'h00);
      hold(LS_K, 1);
   endtask

   task automatic t_eop();
      logic [7:0] d;
      hold(LS_SE0, 4); hold(LS_J, 1);
      chk("R5 EOP at min length", {7'd0, alt}, 8'h01);
      reg_rd(1'b0, d); chk("R5 EOP bit", d, 8'h01);
      hold(LS_K, 1); hold(LS_SE0, 3); hold(LS_J, 1);
      chk("R5 short SE0 no EOP", {7'd0, alt}, 8'h00);
      hold(LS_K, 1); hold(LS_SE0, 19); hold(LS_J, 1);
      chk("R5 EOP at max length", {7'd0, alt}, 8'h01);
      reg_rd(1'b0, d); chk("R5 EOP bit max", d, 8'h01);
      hold(LS_K, 1); hold(LS_SE0, 5); hold(LS_K, 1);
      chk("R5 SE0 ending in K no EOP", {7'd0, alt}, 8'h00);
   endtask

   task automatic t_resume();
      logic [7:0] d;
      hold(LS_J, 1); hold(LS_K, 1);
      chk("R6 no resume when awake", {7'd0, alt}, 8'h00);
      susp = 1'b1;
      hold(LS_K, 2); chk("R6 no resume without idle first", {7'd0, alt}, 8'h00);
      hold(LS_J, 1); hold(LS_K, 1);
      chk("R6 resume while suspended", {7'd0, alt}, 8'h01);
      reg_rd(1'b0, d); chk("R6 resume bit", d, 8'h10);
      hold(LS_K, 5); chk("R6 once per non-idle run", {7'd0, alt}, 8'h00);
      hold(LS_J, 1); hold(LS_SE0, 1);
      chk("R6 resume on SE0", {7'd0, alt}, 8'h01);
      reg_rd(1'b0, d); chk("R6 resume bit on SE0", d, 8'h10);
      susp = 1'b0;
      hold(LS_K, 1);
   endtask

   task automatic t_coincide();
      logic [7:0] d;
      hold(LS_SE0, 19);
      reg_rd(1'b0, d); chk("R7 read in event cycle shows old value", d, 8'h00);
      chk("R7 event kept despite read", {7'd0, alt}, 8'h01);
      reg_rd(1'b0, d); chk("R7 flag readable after coincidence", d, 8'h08);
      reg_rd(1'b0, d); chk("R7 cleared by read", d, 8'h00);
      hold(LS_K, 1);
   endtask

   task automatic t_masking();
      logic [7:0] d;
      reg_wr(1'b1, 8'h02);
      hold(LS_SE0, 4); hold(LS_J, 1);
      chk("R9 masked event no alt", {7'd0, alt}, 8'h00);
      reg_wr(1'b1, 8'h01);
      chk("R9 unmask raises alt", {7'd0, alt}, 8'h01);
      reg_rd(1'b0, d); chk("R9 masked flag still set", d, 8'h01);
      chk("R9 alt drops after clear", {7'd0, alt}, 8'h00);
      hold(LS_K, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mask_rw();
      t_idle();
      t_busreset();
      t_eop();
      t_resume();
      t_coincide();
      t_masking();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", WD_CYCLES, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule